// File: doc/BRIEF.md
# Programmable Down-Count Timer with Prescaler

This block is a count-down timer that sits beside a processor's interrupt logic. Software sets up the timer through a small register window. A vector-entry register holds the interrupt vector, the periodic/one-shot selection and a mask bit. A prescaler register selects how many clock cycles make one count step. Writing the start value arms the timer. When the count runs out, the block raises a one-cycle request on `irq_pulse` and presents the vector on `irq_vector`.

The sequencing is a two-state machine.

- **ST_IDLE**: the timer is stopped.
- **ST_RUN**: the timer is counting.

It has four transitions.

- **LOAD**: a write to the start-value register, from either state, goes to ST_RUN.
- **STEP**: in ST_RUN, a prescaled tick with a count above one decrements the count.
- **RELOAD**: in ST_RUN and periodic mode, expiry stays in ST_RUN and refills the count from the start value.
- **EXPIRE**: in ST_RUN and one-shot mode, expiry returns to ST_IDLE with the count at zero.

Register select codes on `reg_addr` are as follows.

| Code | Register | Access |
|------|----------|--------|
| 0 | Vector entry | read/write |
| 1 | Start value | read/write |
| 2 | Current count | read-only |
| 3 | Prescaler | read/write |

Read data is combinational from `reg_addr`. A write takes effect at the clock edge where `reg_wr` is high.

Top module: `lt_timer`

## Requirements
- R1: After reset, all four registers read 0, the timer is in ST_IDLE and `irq_pulse` is low.
- R2: The prescaler register stores only bits 3, 1 and 0 of the written data. Every other bit reads back as 0.
- R3: The prescaler code is {bit3, bit1, bit0}. Code 7 gives one count step per clock. Any other code c gives one step every 2^(c+1) clocks. The first step after a start-value write comes that many clocks after the write edge.
- R4: A start-value write loads the current count at the same edge, enters ST_RUN and clears the prescaler phase. This applies even when the timer is already running, so the following expiry is timed from the new write only.
- R5: The vector-entry register keeps only the bits under mask 0x000310FF. Bit 17 selects periodic mode, bit 16 is the mask, and bits 7:0 are the vector.
- R6: In one-shot mode, a start value N and step period F give exactly one request at N*F clocks after the write edge. After that request the current count is 0 and no further request follows.
- R7: In periodic mode, each expiry raises a request and reloads the current count from the start value. Requests recur every N*F clocks.
- R8: Each expiry raises `irq_pulse` for one clock. During that clock, `irq_vector` equals bits 7:0 of the vector entry as it was before the expiry edge.
- R9: When mask bit 16 is set, expiries raise no request, but counting and reloading continue.
- R10: A write to the current-count register has no effect on the count.
- R11: In periodic mode with a start value of 0, the count stays at 0 and every step is an expiry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected register |
| irq_pulse | output | 1 | One-cycle interrupt request |
| irq_vector | output | 8 | Vector carried with the request |

## Verification
The assertions assume that `reg_addr` is a settled, known value whenever `reg_wr` is high. They also assume that the prescaler code is not rewritten while the timer runs, because that would break the step-size bound. The stimulus rewrites the prescaler and the vector entry only while the timer is idle or masked, with one exception. In one sequence the vector entry is changed in the same edge as an expiry, so that the request is seen to use the old entry. A scoreboard queue holds the cycle and vector of every request the bench predicts, and any request or silence outside those predictions is reported.

// File: rtl/lt_pkg.sv
package lt_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

    typedef enum logic [1:0] {
        SEL_VECTOR  = 2'd0,
        SEL_INIT    = 2'd1,
        SEL_CURRENT = 2'd2,
        SEL_DIVIDE  = 2'd3
    } reg_sel_e;

    localparam logic [31:0] VECTOR_KEEP  = 32'h0003_10FF;
    localparam int          PERIODIC_BIT = 17;
    localparam int          MASK_BIT     = 16;
    localparam int          DIV_CODE_W   = 3;
    localparam int          PRE_W        = 7;

    // Prescaler terminal value (factor minus one) for a 3-bit code.
    function automatic logic [PRE_W-1:0] div_limit(input logic [DIV_CODE_W-1:0] code);
        logic [PRE_W:0] factor;
        factor = (code == 3'd7) ? (PRE_W+1)'(1) : ((PRE_W+1)'(2) << code);
        return PRE_W'(factor - (PRE_W+1)'(1));
    endfunction

endpackage

// File: rtl/lt_regs.sv
module lt_regs
    import lt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic [1:0]            reg_addr,
    input  logic [CNT_W-1:0]      reg_wdata,
    output logic [CNT_W-1:0]      vec_entry,
    output logic [CNT_W-1:0]      init_cnt,
    output logic [DIV_CODE_W-1:0] div_code,
    output logic                  load
);

    localparam logic [CNT_W-1:0] KEEP = CNT_W'(VECTOR_KEEP);

    assign load = reg_wr && (reg_sel_e'(reg_addr) == SEL_INIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_entry <= '0;
            init_cnt  <= '0;
            div_code  <= '0;
        end else if (reg_wr) begin
            unique case (reg_sel_e'(reg_addr))
                SEL_VECTOR:  vec_entry <= reg_wdata & KEEP;
                SEL_INIT:    init_cnt  <= reg_wdata;
                SEL_CURRENT: ;
                SEL_DIVIDE:  div_code  <= {reg_wdata[3], reg_wdata[1], reg_wdata[0]};
            endcase
        end
    end

endmodule

// File: rtl/lt_prescaler.sv
module lt_prescaler
    import lt_pkg::*;
#(
    parameter int PW = PRE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic          restart,
    input  logic [PW-1:0] limit,
    output logic          tick
);

    logic [PW-1:0] phase;

    assign tick = active && !restart && (phase >= limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (restart || !active) begin
            phase <= '0;
        end else begin
            phase <= tick ? '0 : phase + PW'(1);
        end
    end

endmodule

// File: rtl/lt_countdown.sv
module lt_countdown
    import lt_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             tick,
    input  logic             periodic,
    input  logic             masked,
    input  logic [VEC_W-1:0] vec,
    output logic [CNT_W-1:0] cur_cnt,
    output logic             running,
    output logic             irq,
    output logic [VEC_W-1:0] irq_vec
);

    run_state_e       state_q, state_d;
    logic [CNT_W-1:0] cur_d;
    logic             expire;

    assign running = (state_q == ST_RUN);
    assign expire  = running && tick && !load && (cur_cnt <= CNT_W'(1));

    always_comb begin
        state_d = state_q;
        cur_d   = cur_cnt;
        if (load) begin
            state_d = ST_RUN;                       // LOAD
            cur_d   = load_val;
        end else begin
            unique case (state_q)
                ST_IDLE: ;
                ST_RUN: begin
                    if (tick) begin
                        if (cur_cnt > CNT_W'(1)) begin
                            cur_d = cur_cnt - CNT_W'(1);  // STEP
                        end else if (periodic) begin
                            cur_d = reload_val;           // RELOAD
                        end else begin
                            cur_d   = '0;                 // EXPIRE
                            state_d = ST_IDLE;
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cur_cnt <= '0;
        end else begin
            state_q <= state_d;
            cur_cnt <= cur_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq     <= 1'b0;
            irq_vec <= '0;
        end else begin
            irq <= expire && !masked;
            if (expire) irq_vec <= vec;
        end
    end

endmodule

// File: rtl/lt_timer.sv
module lt_timer
    import lt_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [CNT_W-1:0] reg_wdata,
    output logic [CNT_W-1:0] reg_rdata,
    output logic             irq_pulse,
    output logic [VEC_W-1:0] irq_vector
);

    logic [CNT_W-1:0]      lvt_q;
    logic [CNT_W-1:0]      init_cnt;
    logic [CNT_W-1:0]      cur_cnt;
    logic [DIV_CODE_W-1:0] div_code;
    logic                  load;
    logic                  tick;
    logic                  run_w;

    lt_regs #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .vec_entry (lvt_q),
        .init_cnt  (init_cnt),
        .div_code  (div_code),
        .load      (load)
    );

    lt_prescaler #(.PW(PRE_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (run_w),
        .restart (load),
        .limit   (div_limit(div_code)),
        .tick    (tick)
    );

    lt_countdown #(.CNT_W(CNT_W), .VEC_W(VEC_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .load_val   (reg_wdata),
        .reload_val (init_cnt),
        .tick       (tick),
        .periodic   (lvt_q[PERIODIC_BIT]),
        .masked     (lvt_q[MASK_BIT]),
        .vec        (lvt_q[VEC_W-1:0]),
        .cur_cnt    (cur_cnt),
        .running    (run_w),
        .irq        (irq_pulse),
        .irq_vec    (irq_vector)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (reg_sel_e'(reg_addr))
            SEL_VECTOR:  reg_rdata = lvt_q;
            SEL_INIT:    reg_rdata = init_cnt;
            SEL_CURRENT: reg_rdata = cur_cnt;
            SEL_DIVIDE: begin
                reg_rdata[3] = div_code[2];
                reg_rdata[1] = div_code[1];
                reg_rdata[0] = div_code[0];
            end
        endcase
    end

endmodule

// File: rtl/lt_timer_chk.sv
module lt_timer_chk #(
    parameter int CNT_W = 32,
    parameter int VEC_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic [1:0]       reg_addr,
    input logic [CNT_W-1:0] reg_wdata,
    input logic [CNT_W-1:0] reg_rdata,
    input logic             irq_pulse,
    input logic [VEC_W-1:0] irq_vector,
    input logic             run,
    input logic [CNT_W-1:0] cur_cnt,
    input logic [CNT_W-1:0] lvt_q
);

    logic load_c;
    assign load_c = reg_wr && (reg_addr == 2'd1);

    p_div_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 2'd3) |-> ((reg_rdata & ~CNT_W'(32'hB)) == '0));

    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load_c && cur_cnt > CNT_W'(1)) |=>
        (cur_cnt == $past(cur_cnt) || cur_cnt == $past(cur_cnt) - CNT_W'(1)));

    p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load_c |=> (run && cur_cnt == $past(reg_wdata)));

    p_vec_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 2'd0) |-> ((reg_rdata & ~CNT_W'(32'h0003_10FF)) == '0));

    p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load_c) |=> ($stable(cur_cnt) && !run));

    p_vector_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> (irq_vector == $past(lvt_q[VEC_W-1:0])));

    p_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> !$past(lvt_q[16]));

    p_cur_ro_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd2 && !run) |=> $stable(cur_cnt));

endmodule

bind lt_timer lt_timer_chk #(.CNT_W(CNT_W), .VEC_W(VEC_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .irq_pulse  (irq_pulse),
    .irq_vector (irq_vector),
    .run        (run_w),
    .cur_cnt    (cur_cnt),
    .lvt_q      (lvt_q)
);

// File: tb/lt_timer_tb_top.sv
module lt_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_pulse;
    logic [7:0]  irq_vector;

    int total = 0;
    int fails = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    typedef struct {
        int         at;
        logic [7:0] vec;
        string      tag;
    } exp_t;
    exp_t exp_q[$];

    always #5ns clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    lt_timer dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .irq_pulse  (irq_pulse),
        .irq_vector (irq_vector)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] d, output int at);
        reg_wr    = 1'b1;
        reg_addr  = sel;
        reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
        at = cyc;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [31:0] d);
        reg_addr = sel;
        #1ns;
        d = reg_rdata;
    endtask

    task automatic expect_irq(input int at, input logic [7:0] v, input string tag);
        exp_t e;
        e.at = at; e.vec = v; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Monitor: compare every request against the scoreboard queue.
    always @(negedge clk) begin
        if (rst_n) begin
            if (exp_q.size() > 0 && cyc > exp_q[0].at) begin
                check(1'b0, {exp_q[0].tag, " missed request"}, 0, 1);
                void'(exp_q.pop_front());
            end
            if (irq_pulse) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R6/R9 unexpected request", cyc, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(cyc == e.at, {e.tag, " request cycle"}, cyc, e.at);
                    check(irq_vector == e.vec, {e.tag, " R8 vector"}, irq_vector, e.vec);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int w, w2, v, t;

        step(3);
        rst_n = 1'b1;
        step(1);

        // R1: reset state
        for (int s = 0; s < 4; s++) begin
            rd(s[1:0], d);
            check(d == 0, "R1 reset read", d, 0);
        end
        check(irq_pulse == 1'b0, "R1 irq low", irq_pulse, 0);

        // R2: prescaler write mask
        wr(2'd3, 32'hFFFF_FFFF, t);
        rd(2'd3, d);
        check(d == 32'hB, "R2 divide readback", d, 32'hB);

        // R5: vector entry mask
        wr(2'd0, 32'hFFFF_FFFF, t);
        rd(2'd0, d);
        check(d == 32'h0003_10FF, "R5 vector readback", d, 32'h0003_10FF);

        // R6/R3/R10: one-shot, divide by 2
        wr(2'd3, 32'h0, t);
        wr(2'd0, 32'h42, t);
        wr(2'd1, 32'd5, w);
        rd(2'd2, d);
        check(d == 5, "R4 immediate load", d, 5);
        expect_irq(w + 10, 8'h42, "R6");
        step(4);
        rd(2'd2, d);
        check(d == 3, "R3 divide-by-2 count", d, 3);
        wr(2'd2, 32'd1234, t);
        rd(2'd2, d);
        check(d == 3, "R10 current count write ignored", d, 3);
        step(5);
        rd(2'd2, d);
        check(d == 0, "R6 count after expiry", d, 0);
        step(1);
        check(irq_pulse == 1'b0, "R8 one-cycle pulse", irq_pulse, 0);
        step(20);
        rd(2'd2, d);
        check(d == 0, "R6 stays idle", d, 0);

        // R4: restart while running
        wr(2'd0, 32'h55, t);
        wr(2'd1, 32'd6, w);
        step(3);
        wr(2'd1, 32'd4, w2);
        rd(2'd2, d);
        check(d == 4, "R4 restart load", d, 4);
        expect_irq(w2 + 8, 8'h55, "R4");
        step(8);
        rd(2'd2, d);
        check(d == 0, "R4 expiry after restart", d, 0);

        // R3: code 5 -> divide by 64
        wr(2'd3, 32'h9, t);
        wr(2'd0, 32'h12, t);
        wr(2'd1, 32'd2, w);
        expect_irq(w + 128, 8'h12, "R3");
        step(63);
        rd(2'd2, d);
        check(d == 2, "R3 before first step /64", d, 2);
        step(1);
        rd(2'd2, d);
        check(d == 1, "R3 first step /64", d, 1);
        step(64);
        rd(2'd2, d);
        check(d == 0, "R3 expiry /64", d, 0);

        // R7: periodic, divide by 1
        wr(2'd3, 32'hB, t);
        wr(2'd0, 32'h0002_0031, t);
        wr(2'd1, 32'd3, w);
        expect_irq(w + 3, 8'h31, "R7");
        expect_irq(w + 6, 8'h31, "R7");
        expect_irq(w + 9, 8'h31, "R7");
        step(9);
        rd(2'd2, d);
        check(d == 3, "R7 reload", d, 3);

        // R9: masked periodic keeps counting
        wr(2'd0, 32'h0003_0031, t);
        wr(2'd1, 32'd3, w2);
        step(7);
        rd(2'd2, d);
        check(d == 2, "R9 masked still counting", d, 2);

        // R11: periodic with start value 0
        wr(2'd1, 32'd0, w);
        wr(2'd0, 32'h0002_0077, v);
        for (int k = 1; k <= 5; k++) expect_irq(v + k, 8'h77, "R11");
        step(4);
        wr(2'd0, 32'h0003_0077, t);
        rd(2'd2, d);
        check(d == 0, "R11 count stays zero", d, 0);
        step(10);

        check(exp_q.size() == 0, "R6 scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule